// File: doc/BRIEF.md
# Parallel Flash Programming Controller

This block is the device-side controller that drives a small on-chip code flash while the chip sits in parallel programming mode. An external programmer presents a mode code, a byte address and a data byte. It then pulls a program strobe low. The controller can write one code byte, set one of three lock bits, or erase the whole array. Each of these operations then runs to completion on an internal timer, and a ready/busy output signals the programmer when the next command may be sent.

Reads need no strobe and no programming voltage. The shared data output shows one of three things, chosen by the mode: a code byte, the lock-bit status, or one of three fixed signature bytes. The lock bits guard the array. The first lock bit blocks code writes. The second lock bit hides code contents on reads. Only a chip erase clears the lock bits.

The array is held in an internal register memory of 2^ADDR_W bytes. Chip erase sweeps the array one address per clock. The erase time is the larger of ERASE_CYC and the array depth.

Top module: `pflash_prog_ctrl`

## Requirements
- R1: The mode code on mode_i selects the operation, encoded as 0 read code, 1 write code, 2 read locks, 3 read signature, 4/5/6 set lock bit 1/2/3, 7 chip erase. A write-code operation stores data_i at addr_i. After it completes, a read-code access at that address returns the stored byte.
- R2: A falling edge on strobe_ni is detected through a two-flop synchroniser, so ready_o goes low on the third rising clock edge after the fall. ready_o then stays low for exactly WRITE_CYC cycles for a code write or lock write. For a chip erase it stays low for max(ERASE_CYC, 2^ADDR_W) cycles.
- R3: Mode, address and data are captured when an operation starts. Strobe edges and input changes that arrive while ready_o is low have no effect.
- R4: Write, lock and erase strobes start nothing while hv_en_i is low: ready_o stays high and the array is unchanged. Reads work with hv_en_i low.
- R5: While pgm_act_i is low, every strobe is ignored and data_o is 0x00.
- R6: In read-signature mode, address 0x000 returns 0x1E, address 0x001 returns 0x52 and address 0x002 returns 0x06. Every other address returns 0x00.
- R7: In read-lock mode, lock bits 1, 2 and 3 appear on data_o bits 2, 3 and 4. All other bits of data_o are 0.
- R8: Modes 4, 5 and 6 each set only their own lock bit, once the timed operation ends.
- R9: While lock bit 1 is set, a write-code strobe starts no operation and leaves the array unchanged.
- R10: While lock bit 2 is set, read-code accesses return 0xFF. Signature reads are unaffected.
- R11: Chip erase sets every array byte to 0xFF and clears all three lock bits. Apart from rst_ni, nothing else clears a lock bit.
- R12: After reset, ready_o is high and all lock bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset of the controller logic |
| pgm_act_i | input | 1 | Programming-mode enable; must be high for any mode to act |
| hv_en_i | input | 1 | High-voltage enable; high permits write, lock and erase |
| mode_i | input | 3 | Operation select code |
| addr_i | input | ADDR_W | Byte address |
| data_i | input | 8 | Write data |
| strobe_ni | input | 1 | Active-low program strobe, asynchronous |
| data_o | output | 8 | Read data |
| ready_o | output | 1 | High when idle, low while a timed operation runs |

## Verification
The bench builds the block with ADDR_W=13, so the full 8K array is present and the erase sweep has to reach address 0x1FFF. WRITE_CYC=12 keeps each busy window short enough that a second strobe and new inputs can be placed inside it, and the cycle count of the window can be checked exactly. ERASE_CYC=9000 is larger than the array depth, so the erase length comes from the timer rather than from the sweep. Two erases fit easily within the run.

// File: rtl/pfp_pkg.sv
package pfp_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned NUM_LOCK = 3;

  typedef enum logic [2:0] {
    MD_RD_CODE = 3'd0,
    MD_WR_CODE = 3'd1,
    MD_RD_LOCK = 3'd2,
    MD_RD_SIG  = 3'd3,
    MD_WR_LK1  = 3'd4,
    MD_WR_LK2  = 3'd5,
    MD_WR_LK3  = 3'd6,
    MD_ERASE   = 3'd7
  } pfp_mode_e;

  function automatic logic [DATA_W-1:0] sig_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    sig_byte = 8'h1E;
      2'd1:    sig_byte = 8'h52;
      2'd2:    sig_byte = 8'h06;
      default: sig_byte = 8'h00;
    endcase
  endfunction

  function automatic logic is_prog(input pfp_mode_e m);
    is_prog = (m == MD_WR_CODE) || (m == MD_WR_LK1) || (m == MD_WR_LK2) ||
              (m == MD_WR_LK3) || (m == MD_ERASE);
  endfunction
endpackage

// File: rtl/pfp_strobe_det.sv
module pfp_strobe_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic strobe_ni,
  output logic fall_o
);
  logic [SYNC_STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[SYNC_STAGES-1:0], strobe_ni};
  end

  // synchronised level low, previous level high
  assign fall_o = sh_q[SYNC_STAGES] & ~sh_q[SYNC_STAGES-1];
endmodule

// File: rtl/pfp_seq.sv
module pfp_seq
  import pfp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned WRITE_CYC = 64,
  parameter int unsigned ERASE_LEN = 16384,
  localparam int unsigned CNT_W    = $clog2(ERASE_LEN + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  pfp_mode_e         mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              done_o,
  output pfp_mode_e         op_mode_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              sweep_en_o,
  output logic [ADDR_W-1:0] sweep_addr_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [ADDR_W:0]  sweep_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      cnt_q     <= '0;
      sweep_q   <= '0;
      op_mode_o <= MD_RD_CODE;
      op_addr_o <= '0;
      op_data_o <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q    <= 1'b1;
        op_mode_o <= mode_i;
        op_addr_o <= addr_i;
        op_data_o <= data_i;
        sweep_q   <= '0;
        cnt_q     <= (mode_i == MD_ERASE) ? CNT_W'(ERASE_LEN - 1) : CNT_W'(WRITE_CYC - 1);
      end
    end else begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
      if (sweep_en_o)  sweep_q <= sweep_q + 1'b1;
    end
  end

  assign busy_o       = busy_q;
  assign done_o       = busy_q && (cnt_q == '0);
  assign sweep_en_o   = busy_q && (op_mode_o == MD_ERASE) && !sweep_q[ADDR_W];
  assign sweep_addr_o = sweep_q[ADDR_W-1:0];
endmodule

// File: rtl/pfp_array.sv
module pfp_array
  import pfp_pkg::*;
#(
  parameter int unsigned ADDR_W = 13,
  localparam int unsigned DEPTH = 1 << ADDR_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [DATA_W-1:0]   wr_data_i,
  input  logic                sweep_en_i,
  input  logic [ADDR_W-1:0]   sweep_addr_i,
  input  logic [NUM_LOCK-1:0] lock_set_i,
  input  logic                lock_clr_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [DATA_W-1:0]   rd_data_o,
  output logic [NUM_LOCK-1:0] lock_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (sweep_en_i)   mem_q[sweep_addr_i] <= '1;
    else if (wr_en_i) mem_q[wr_addr_i]    <= wr_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         lock_o <= '0;
    else if (lock_clr_i) lock_o <= '0;
    else                 lock_o <= lock_o | lock_set_i;
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/pflash_prog_ctrl.sv
module pflash_prog_ctrl
  import pfp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned WRITE_CYC = 64,
  parameter int unsigned ERASE_CYC = 16384,
  localparam int unsigned DEPTH     = 1 << ADDR_W,
  localparam int unsigned ERASE_LEN = (ERASE_CYC > DEPTH) ? ERASE_CYC : DEPTH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pgm_act_i,
  input  logic              hv_en_i,
  input  logic [2:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  input  logic              strobe_ni,
  output logic [7:0]        data_o,
  output logic              ready_o
);
  pfp_mode_e           mode;
  logic                fall, start, busy, done, sweep_en;
  pfp_mode_e           op_mode;
  logic [ADDR_W-1:0]   op_addr, sweep_addr;
  logic [DATA_W-1:0]   op_data, rd_data;
  logic [NUM_LOCK-1:0] lock, lock_set;
  logic                wr_en, lock_clr, wr_blocked;

  assign mode = pfp_mode_e'(mode_i);

  pfp_strobe_det #(.SYNC_STAGES(2)) u_strobe (
    .clk_i, .rst_ni, .strobe_ni, .fall_o(fall)
  );

  assign wr_blocked = (mode == MD_WR_CODE) && lock[0];
  assign start = fall && pgm_act_i && hv_en_i && is_prog(mode) && !wr_blocked && !busy;

  pfp_seq #(
    .ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC), .ERASE_LEN(ERASE_LEN)
  ) u_seq (
    .clk_i, .rst_ni,
    .start_i(start), .mode_i(mode), .addr_i, .data_i,
    .busy_o(busy), .done_o(done),
    .op_mode_o(op_mode), .op_addr_o(op_addr), .op_data_o(op_data),
    .sweep_en_o(sweep_en), .sweep_addr_o(sweep_addr)
  );

  assign wr_en    = done && (op_mode == MD_WR_CODE);
  assign lock_clr = done && (op_mode == MD_ERASE);

  for (genvar g = 0; g < NUM_LOCK; g++) begin : g_lock
    assign lock_set[g] = done && (op_mode == pfp_mode_e'(MD_WR_LK1 + g));
  end

  pfp_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i, .rst_ni,
    .wr_en_i(wr_en), .wr_addr_i(op_addr), .wr_data_i(op_data),
    .sweep_en_i(sweep_en), .sweep_addr_i(sweep_addr),
    .lock_set_i(lock_set), .lock_clr_i(lock_clr),
    .rd_addr_i(addr_i), .rd_data_o(rd_data), .lock_o(lock)
  );

  always_comb begin
    data_o = '0;
    if (pgm_act_i) begin
      unique case (mode)
        MD_RD_CODE: data_o = lock[1] ? 8'hFF : rd_data;
        MD_RD_LOCK: data_o = {3'b000, lock, 2'b00};
        MD_RD_SIG:  data_o = (addr_i < ADDR_W'(3)) ? sig_byte(addr_i[1:0]) : 8'h00;
        default:    data_o = '0;
      endcase
    end
  end

  assign ready_o = !busy;
endmodule

// File: rtl/pfp_checker.sv
module pfp_checker #(
  parameter int unsigned ADDR_W    = 13,
  parameter int unsigned WRITE_CYC = 64,
  parameter int unsigned ERASE_LEN = 16384
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              pgm_act_i,
  input logic              hv_en_i,
  input logic [2:0]        mode_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [7:0]        data_o,
  input logic              ready_o
);
  logic [31:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       low_run <= '0;
    else if (!ready_o) low_run <= low_run + 1;
    else               low_run <= '0;
  end

  assert_busy_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ready_o) |-> (low_run == WRITE_CYC || low_run == ERASE_LEN));

  assert_hv_gate_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(hv_en_i && pgm_act_i));

  assert_inactive_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pgm_act_i |-> data_o == 8'h00);

  assert_sig_zero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pgm_act_i && mode_i == 3'd3 && addr_i == '0) |-> data_o == 8'h1E);

  assert_lock_fmt_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 3'd2) |-> (data_o[7:5] == 3'b000 && data_o[1:0] == 2'b00));
endmodule

bind pflash_prog_ctrl pfp_checker #(
  .ADDR_W(ADDR_W), .WRITE_CYC(WRITE_CYC), .ERASE_LEN(ERASE_LEN)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pgm_act_i(pgm_act_i), .hv_en_i(hv_en_i),
  .mode_i(mode_i), .addr_i(addr_i), .data_o(data_o), .ready_o(ready_o)
);

// File: tb/sim_pflash_prog_ctrl.sv
module sim_pflash_prog_ctrl;
  localparam int AW = 13;
  localparam int WCYC = 12;
  localparam int ECYC = 9000;
  localparam int ELEN = 9000;

  localparam logic [2:0] RD_CODE = 3'd0, WR_CODE = 3'd1, RD_LOCK = 3'd2, RD_SIG = 3'd3,
                         WR_LK1 = 3'd4, WR_LK2 = 3'd5, WR_LK3 = 3'd6, ERASE = 3'd7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          pgm_act = 1'b1;
  logic          hv_en = 1'b1;
  logic [2:0]    mode = RD_CODE;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic          strobe_n = 1'b1;
  logic [7:0]    dout;
  logic          ready;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pflash_prog_ctrl #(.ADDR_W(AW), .WRITE_CYC(WCYC), .ERASE_CYC(ECYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pgm_act_i(pgm_act), .hv_en_i(hv_en),
    .mode_i(mode), .addr_i(addr), .data_i(din), .strobe_ni(strobe_n),
    .data_o(dout), .ready_o(ready)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] m, input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    mode = m;
    addr = a;
    #2 d = dout;
  endtask

  // drives a strobe pulse; optional second pulse with new inputs inside the busy window
  task automatic op(input logic [2:0] m, input logic [AW-1:0] a, input logic [7:0] d,
                    input bit extra, output int len, output int first);
    len = 0;
    first = -1;
    @(negedge clk);
    mode = m; addr = a; din = d; strobe_n = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (i == 2) strobe_n = 1'b1;
      if (extra && i == 5) begin
        addr = a + 1'b1; din = 8'h22; mode = WR_LK1; strobe_n = 1'b0;
      end
      if (extra && i == 8) strobe_n = 1'b1;
      if (!ready) begin
        if (first < 0) first = i;
        len++;
      end else if (len > 0 || i >= 10) begin
        break;
      end
    end
    mode = RD_CODE;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 ready in reset", ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ready after reset", ready, 1);
    rd(RD_LOCK, '0, d);
    chk("R12 locks clear", d, 8'h00);
  endtask

  task automatic t_erase(input string tag);
    int len, first;
    logic [7:0] d;
    op(ERASE, '0, '0, 1'b0, len, first);
    chk({"R2 erase length ", tag}, len, ELEN);
    chk({"R2 erase start latency ", tag}, first, 2);
    rd(RD_CODE, 13'h0000, d); chk({"R11 erased low ", tag}, d, 8'hFF);
    rd(RD_CODE, 13'h1FFF, d); chk({"R11 erased top ", tag}, d, 8'hFF);
    rd(RD_CODE, 13'h0ABC, d); chk({"R11 erased mid ", tag}, d, 8'hFF);
    rd(RD_LOCK, '0, d);       chk({"R11 locks cleared ", tag}, d, 8'h00);
  endtask

  task automatic t_write();
    int len, first;
    logic [7:0] d;
    op(WR_CODE, 13'h0005, 8'hA5, 1'b0, len, first);
    chk("R2 write length", len, WCYC);
    chk("R2 write start latency", first, 2);
    op(WR_CODE, 13'h1FFF, 8'h3C, 1'b0, len, first);
    chk("R1 write top length", len, WCYC);
    rd(RD_CODE, 13'h0005, d); chk("R1 readback 0005", d, 8'hA5);
    rd(RD_CODE, 13'h1FFF, d); chk("R1 readback 1FFF", d, 8'h3C);
    rd(RD_CODE, 13'h0006, d); chk("R1 neighbour untouched", d, 8'hFF);
  endtask

  task automatic t_sig();
    logic [7:0] d;
    hv_en = 1'b0;
    rd(RD_SIG, 13'h000, d); chk("R6 sig 0", d, 8'h1E);
    rd(RD_SIG, 13'h001, d); chk("R6 sig 1", d, 8'h52);
    rd(RD_SIG, 13'h002, d); chk("R6 sig 2", d, 8'h06);
    rd(RD_SIG, 13'h003, d); chk("R6 sig other", d, 8'h00);
    rd(RD_CODE, 13'h0005, d); chk("R4 read with hv low", d, 8'hA5);
    hv_en = 1'b1;
  endtask

  task automatic t_hv_low();
    int len, first;
    logic [7:0] d;
    hv_en = 1'b0;
    op(WR_CODE, 13'h0005, 8'h00, 1'b0, len, first);
    chk("R4 write ignored no busy", len, 0);
    op(ERASE, '0, '0, 1'b0, len, first);
    chk("R4 erase ignored no busy", len, 0);
    hv_en = 1'b1;
    rd(RD_CODE, 13'h0005, d); chk("R4 data kept 0005", d, 8'hA5);
    rd(RD_CODE, 13'h1FFF, d); chk("R4 data kept 1FFF", d, 8'h3C);
  endtask

  task automatic t_pgm_off();
    int len, first;
    logic [7:0] d;
    pgm_act = 1'b0;
    rd(RD_CODE, 13'h0005, d); chk("R5 output zero code", d, 8'h00);
    rd(RD_SIG, 13'h000, d);   chk("R5 output zero sig", d, 8'h00);
    op(WR_CODE, 13'h0006, 8'h77, 1'b0, len, first);
    chk("R5 strobe ignored", len, 0);
    pgm_act = 1'b1;
    rd(RD_CODE, 13'h0006, d); chk("R5 array unchanged", d, 8'hFF);
  endtask

  task automatic t_busy_ignore();
    int len, first;
    logic [7:0] d;
    op(WR_CODE, 13'h0010, 8'h11, 1'b1, len, first);
    chk("R3 length unaffected", len, WCYC);
    rd(RD_CODE, 13'h0010, d); chk("R3 captured write", d, 8'h11);
    rd(RD_CODE, 13'h0011, d); chk("R3 second strobe ignored", d, 8'hFF);
    rd(RD_LOCK, '0, d);       chk("R3 mode change ignored", d, 8'h00);
  endtask

  task automatic t_locks();
    int len, first;
    logic [7:0] d;
    op(WR_LK1, '0, '0, 1'b0, len, first);
    chk("R8 lock1 length", len, WCYC);
    rd(RD_LOCK, '0, d); chk("R7 lock1 on bit2", d, 8'h04);
    op(WR_CODE, 13'h0020, 8'h99, 1'b0, len, first);
    chk("R9 write blocked no busy", len, 0);
    rd(RD_CODE, 13'h0020, d); chk("R9 array unchanged", d, 8'hFF);
    rd(RD_CODE, 13'h0005, d); chk("R10 readable before lock2", d, 8'hA5);
    op(WR_LK2, '0, '0, 1'b0, len, first);
    rd(RD_LOCK, '0, d); chk("R8 lock2 on bit3", d, 8'h0C);
    rd(RD_CODE, 13'h0005, d); chk("R10 hidden read", d, 8'hFF);
    rd(RD_SIG, 13'h001, d);   chk("R10 sig unaffected", d, 8'h52);
    op(WR_LK3, '0, '0, 1'b0, len, first);
    rd(RD_LOCK, '0, d); chk("R8 lock3 on bit4", d, 8'h1C);
  endtask

  task automatic t_after_erase();
    int len, first;
    logic [7:0] d;
    rd(RD_CODE, 13'h0010, d); chk("R11 erased 0010", d, 8'hFF);
    op(WR_CODE, 13'h0020, 8'h99, 1'b0, len, first);
    chk("R9 write allowed after erase", len, WCYC);
    rd(RD_CODE, 13'h0020, d); chk("R1 readback 0020", d, 8'h99);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_erase("first");
    t_write();
    t_sig();
    t_hv_low();
    t_pgm_off();
    t_busy_ignore();
    t_locks();
    t_erase("second");
    t_after_erase();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule